// File: doc/BRIEF.md
# Clock Source Mode Sequencer

This controller decides which operating mode the system clock generator is in. Software writes a 2-bit clock-select field. The sequencer does not simply decode that field: it gates each move on stability handshakes, falls back when the external reference is lost, and recovers from a low-power off state in different ways for an interrupt wake and a reset. The oscillator, the frequency-locked loop arithmetic and the dividers sit outside the block. They appear here only as status inputs (oscillator stable, external reference detected, loss of clock, loop locked) and as control outputs (clock-output enable, internal-reference feed, filter-register write enable).

A crystal is qualified before it is trusted. Every cycle of the external reference is counted, and the crystal counts as usable only once a parameterised number of cycles (4096 by default) has passed with no loss-of-clock event. The stored select field survives a stop that ends with an interrupt. A reset restores every control bit to its default value.

Top module: `clk_mode_seq`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and after it, mode_o is 0 (self-clocked), sel_o is 00, xtal_ok_o is 0 and dbl_out_o is 0. This also applies when reset arrives while the block is off.
- R2: Mode codes are 0 self-clocked, 1 loop engaged internal, 2 loop bypassed external, 3 loop engaged external, 4 off. Select values 00/01/10/11 map to modes 0/1/2/3. sel_o takes the written value on the edge where sel_wr_i is high. When no other condition applies, mode_o takes the value selected by sel_o on the next edge, so writing 00 after 01 or 11 returns the block to mode 0.
- R3: If sel_o bit1 is 1, ext_det_i is 0 and loss_clk_i is 1, and the block is not off, mode_o becomes 0 on the next edge. Once that condition clears, the selected mode is taken again.
- R4: From off, an edge with wake_irq_i high leaves off. With select 10 the block goes to mode 2 directly. With select 00 it goes to mode 0. With select bit0 = 1 it goes to mode 0 and stays there until an edge sees osc_stable_i high, then enters the selected mode.
- R5: filt_we_o equals filt_req_i while mode_o is 0 and is 0 in every other mode (combinational).
- R6: stop_req_i high moves the block to mode 4 on the next edge. clk_en_o is 0 in mode 4, sel_o keeps its value through off and an interrupt wake, and select writes made while off do not end the off state.
- R7: xtal_ok_o becomes 1 after QUAL_CYCLES edges with ref_tick_i high since it was last cleared. In mode 2, clk_en_o stays 0 until xtal_ok_o and ext_det_i are both 1. In mode 3, int_ref_o is 1 until they are.
- R8: loss_clk_i high, or sel_o bit1 = 0, clears the qualification count on the next edge, and the count restarts from zero.
- R9: dbl_out_o rises on a fallback from mode 3 taken while fll_locked_i is 0, stays high while in mode 0, and is 0 in any other mode. A fallback taken while locked leaves it at 0.
- R10: Priority for a single edge: reset, then loss-of-clock fallback, then stop request, then oscillator-stable gating, then the select field. A fallback and a stop request on the same edge give mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset (also the reset wake) |
| sel_wr_i | input | 1 | Select field write strobe |
| sel_wdata_i | input | 2 | Select field write data |
| filt_req_i | input | 1 | Filter register write request |
| ref_tick_i | input | 1 | One pulse per external reference cycle |
| osc_stable_i | input | 1 | Internal oscillator stable |
| ext_det_i | input | 1 | External reference detected |
| loss_clk_i | input | 1 | Loss of external clock |
| fll_locked_i | input | 1 | Frequency-locked loop locked |
| stop_req_i | input | 1 | Request to enter off mode |
| wake_irq_i | input | 1 | Interrupt wake from off mode |
| mode_o | output | 3 | Current mode code |
| sel_o | output | 2 | Stored select field |
| clk_en_o | output | 1 | Clock output enable |
| int_ref_o | output | 1 | Output fed from the internal reference |
| xtal_ok_o | output | 1 | Crystal qualified |
| dbl_out_o | output | 1 | Output-doubled flag after an unlocked fallback |
| filt_we_o | output | 1 | Gated filter register write enable |

## Verification
A select write shows on sel_o one edge after the strobe and on mode_o one edge later. Fallback, stop entry, wake and oscillator-stable steps each show on mode_o one edge after the input changes. The qualification flag rises exactly on the QUAL_CYCLES-th counted edge. filt_we_o, clk_en_o and int_ref_o follow the registered state with no further delay. The bench drives inputs 1 ns after a rising edge, advances by whole edges, and samples 1 ns after the edge at which each result is due, so every check lands on the first cycle the value may be valid. For the qualification limit it checks the cycle before as well.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

   typedef enum logic [2:0] {
      MODE_SELF     = 3'd0,
      MODE_LOOP_INT = 3'd1,
      MODE_BYP_EXT  = 3'd2,
      MODE_LOOP_EXT = 3'd3,
      MODE_OFF      = 3'd4
   } clk_mode_e;

   typedef logic [1:0] sel_t;

   // Select value to the mode it requests once all gating is satisfied
   function automatic clk_mode_e mode_of_sel(input sel_t s);
      return clk_mode_e'({1'b0, s});
   endfunction

endpackage

// File: rtl/cms_sync.sv
module cms_sync #(
   parameter int unsigned STAGES = 0,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cms_qual_counter.sv
module cms_qual_counter #(
   parameter int unsigned QUAL_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic ok
);
   localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);

   generate
      if (QUAL_CYCLES < 1) begin : g_bad
         $error("QUAL_CYCLES must be at least 1");
      end

      if (QUAL_CYCLES == 1) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ok <= 1'b0;
            else if (clear) ok <= 1'b0;
            else if (tick)  ok <= 1'b1;
         end
      end else begin : g_count
         localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (clear)                  cnt_q <= '0;
            else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end
         assign ok = (cnt_q == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
   import clk_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  sel_t      sel_q,
   input  logic      ext_det,
   input  logic      loss_clk,
   input  logic      fll_locked,
   input  logic      osc_stable,
   input  logic      stop_req,
   input  logic      wake_irq,
   output clk_mode_e mode_q,
   output logic      dco_wait_q,
   output logic      dbl_q
);
   clk_mode_e mode_n;
   logic      dco_wait_n;
   logic      fallback;

   assign fallback = sel_q[1] & ~ext_det & loss_clk;

   always_comb begin
      mode_n     = mode_q;
      dco_wait_n = dco_wait_q;
      if (mode_q == MODE_OFF) begin
         if (wake_irq) begin
            if (sel_q == 2'b10) begin
               mode_n     = MODE_BYP_EXT;
               dco_wait_n = 1'b0;
            end else begin
               mode_n     = MODE_SELF;
               dco_wait_n = sel_q[0];
            end
         end
      end else if (fallback) begin
         mode_n = MODE_SELF;
      end else if (stop_req) begin
         mode_n     = MODE_OFF;
         dco_wait_n = 1'b0;
      end else if (dco_wait_q) begin
         if (osc_stable) begin
            mode_n     = mode_of_sel(sel_q);
            dco_wait_n = 1'b0;
         end
      end else begin
         mode_n = mode_of_sel(sel_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_SELF;
         dco_wait_q <= 1'b0;
         dbl_q      <= 1'b0;
      end else begin
         mode_q     <= mode_n;
         dco_wait_q <= dco_wait_n;
         dbl_q      <= (mode_n == MODE_SELF) &
                       (dbl_q | ((mode_q == MODE_LOOP_EXT) & fallback & ~fll_locked));
      end
   end
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
   import clk_mode_pkg::*;
#(
   parameter int unsigned QUAL_CYCLES = 4096,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_wr_i,
   input  logic [1:0] sel_wdata_i,
   input  logic       filt_req_i,
   input  logic       ref_tick_i,
   input  logic       osc_stable_i,
   input  logic       ext_det_i,
   input  logic       loss_clk_i,
   input  logic       fll_locked_i,
   input  logic       stop_req_i,
   input  logic       wake_irq_i,
   output logic [2:0] mode_o,
   output logic [1:0] sel_o,
   output logic       clk_en_o,
   output logic       int_ref_o,
   output logic       xtal_ok_o,
   output logic       dbl_out_o,
   output logic       filt_we_o
);
   localparam int unsigned NSTAT = 4;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [NSTAT-1:0] stat_raw, stat_s;
   logic ext_s, loss_s, osc_s, lock_s;
   sel_t sel_q;
   clk_mode_e mode_q;
   logic dco_wait_q, dbl_q, xtal_ok, ext_ready;

   assign stat_raw = {ext_det_i, loss_clk_i, osc_stable_i, fll_locked_i};

   cms_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSTAT)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(stat_raw), .q(stat_s)
   );
   assign {ext_s, loss_s, osc_s, lock_s} = stat_s;

   // Select field: returns to 00 on any reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q <= 2'b00;
      else if (sel_wr_i) sel_q <= sel_wdata_i;
   end

   cms_qual_counter #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk(clk), .rst_n(rst_n),
      .clear(loss_s | ~sel_q[1]),
      .tick(ref_tick_i),
      .ok(xtal_ok)
   );

   cms_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sel_q(sel_q),
      .ext_det(ext_s), .loss_clk(loss_s), .fll_locked(lock_s),
      .osc_stable(osc_s), .stop_req(stop_req_i), .wake_irq(wake_irq_i),
      .mode_q(mode_q), .dco_wait_q(dco_wait_q), .dbl_q(dbl_q)
   );

   assign ext_ready = xtal_ok & ext_s;
   assign mode_o    = mode_q;
   assign sel_o     = sel_q;
   assign xtal_ok_o = xtal_ok;
   assign dbl_out_o = dbl_q;
   assign clk_en_o  = (mode_q != MODE_OFF) & ~((mode_q == MODE_BYP_EXT) & ~ext_ready);
   assign int_ref_o = (mode_q == MODE_LOOP_EXT) & ~ext_ready;
   assign filt_we_o = filt_req_i & (mode_q == MODE_SELF);
endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_req_i,
   input logic [1:0] sel_o,
   input logic [2:0] mode_o,
   input logic       clk_en_o,
   input logic       xtal_ok_o,
   input logic       dbl_out_o,
   input logic       filt_we_o,
   input logic       ext_s,
   input logic       loss_s,
   input logic       dco_wait_q
);
   logic fb;
   assign fb = sel_o[1] & ~ext_s & loss_s;

   p_filt_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
      filt_we_o |-> mode_o == 3'd0);
   p_off_no_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd4 |-> !clk_en_o);
   p_stop_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req_i && !fb && mode_o != 3'd4) |=> mode_o == 3'd4);
   p_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fb && mode_o != 3'd4) |=> mode_o == 3'd0);
   p_dbl_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_out_o |-> mode_o == 3'd0);
   p_qual_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      loss_s |=> !xtal_ok_o);
   p_byp_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && !xtal_ok_o) |-> !clk_en_o);
   p_follow_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 3'd4 && !fb && !stop_req_i && !dco_wait_q) |=> mode_o == {1'b0, $past(sel_o)});
endmodule

bind clk_mode_seq clk_mode_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req_i), .sel_o(sel_o),
   .mode_o(mode_o), .clk_en_o(clk_en_o), .xtal_ok_o(xtal_ok_o),
   .dbl_out_o(dbl_out_o), .filt_we_o(filt_we_o),
   .ext_s(ext_s), .loss_s(loss_s), .dco_wait_q(dco_wait_q)
);

// File: tb/test_clk_mode_seq.sv
`timescale 1ns/1ps
module test_clk_mode_seq;
   localparam int QUAL = 4096;
   localparam logic [2:0] M_SELF = 3'd0, M_LINT = 3'd1, M_BYP = 3'd2, M_LEXT = 3'd3, M_OFF = 3'd4;
   // vector: {sel[1:0], loss, ext, expected mode[2:0]}
   localparam int NV = 10;
   localparam logic [6:0] VEC [NV] = '{
      {2'b01, 1'b0, 1'b1, M_LINT}, {2'b11, 1'b0, 1'b1, M_LEXT},
      {2'b10, 1'b0, 1'b1, M_BYP},  {2'b00, 1'b0, 1'b1, M_SELF},
      {2'b11, 1'b0, 1'b1, M_LEXT}, {2'b01, 1'b0, 1'b1, M_LINT},
      {2'b00, 1'b0, 1'b1, M_SELF}, {2'b11, 1'b1, 1'b0, M_SELF},
      {2'b10, 1'b1, 1'b0, M_SELF}, {2'b10, 1'b0, 1'b1, M_BYP}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel_wr = 0, filt_req = 0, ref_tick = 0, osc = 0, ext = 1, loss = 0;
   logic locked = 0, stop = 0, wake = 0;
   logic [1:0] sel_wd = 0;
   logic [2:0] mode;
   logic [1:0] sel;
   logic clk_en, int_ref, xtal_ok, dbl, filt_we;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   clk_mode_seq i_clk_mode_seq (
      .clk(clk), .rst_n(rst_n), .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd),
      .filt_req_i(filt_req), .ref_tick_i(ref_tick), .osc_stable_i(osc),
      .ext_det_i(ext), .loss_clk_i(loss), .fll_locked_i(locked),
      .stop_req_i(stop), .wake_irq_i(wake), .mode_o(mode), .sel_o(sel),
      .clk_en_o(clk_en), .int_ref_o(int_ref), .xtal_ok_o(xtal_ok),
      .dbl_out_o(dbl), .filt_we_o(filt_we));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic write_sel(input logic [1:0] v);
      sel_wd = v; sel_wr = 1; tick(); sel_wr = 0; tick();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk("R1", "mode in reset", mode, M_SELF);
      rst_n = 1; tick();
      chk("R1", "mode after reset", mode, M_SELF);
      chk("R1", "sel after reset", sel, 0);
      chk("R1", "xtal_ok after reset", xtal_ok, 0);
      chk("R1", "dbl after reset", dbl, 0);
      filt_req = 1; #1;
      chk("R5", "filt_we in self", filt_we, 1);

      // Table walk: select writes under different reference status
      for (int v = 0; v < NV; v++) begin
         loss = VEC[v][4]; ext = VEC[v][3];
         write_sel(VEC[v][6:5]);
         chk(VEC[v][2:0] == VEC[v][6:5] ? "R2" : "R3", $sformatf("vector %0d mode", v), mode, VEC[v][2:0]);
         chk("R5", $sformatf("vector %0d filt_we", v), filt_we, VEC[v][2:0] == M_SELF);
      end
      filt_req = 0;
      chk("R7", "bypass clk_en before qualify", clk_en, 0);

      // R7 qualification boundary
      ref_tick = 1;
      tick(QUAL - 1);
      chk("R7", "xtal_ok one short", xtal_ok, 0);
      chk("R7", "clk_en one short", clk_en, 0);
      tick();
      chk("R7", "xtal_ok at limit", xtal_ok, 1);
      chk("R7", "clk_en at limit", clk_en, 1);

      // R8 loss pulse with reference still detected: clear, no fallback
      loss = 1; tick(); loss = 0;
      chk("R8", "xtal_ok cleared by loss", xtal_ok, 0);
      chk("R8", "mode kept in bypass", mode, M_BYP);
      chk("R7", "clk_en low after clear", clk_en, 0);
      tick(QUAL - 1);
      chk("R8", "recount one short", xtal_ok, 0);
      tick();
      chk("R8", "recount complete", xtal_ok, 1);
      ref_tick = 0;

      // Fallback from loop-external while unlocked
      write_sel(2'b11);
      chk("R2", "loop external", mode, M_LEXT);
      chk("R7", "int_ref off once qualified", int_ref, 0);
      locked = 0; ext = 0; loss = 1; tick();
      chk("R3", "fallback to self", mode, M_SELF);
      chk("R9", "dbl raised unlocked", dbl, 1);
      tick();
      chk("R9", "dbl held in self", dbl, 1);
      ext = 1; loss = 0; tick();
      chk("R3", "return to loop external", mode, M_LEXT);
      chk("R9", "dbl cleared", dbl, 0);
      chk("R7", "int_ref after requalify needed", int_ref, 1);
      chk("R8", "count cleared by fallback", xtal_ok, 0);

      locked = 1; ext = 0; loss = 1; tick();
      chk("R9", "dbl not raised when locked", dbl, 0);
      ext = 1; loss = 0; tick();

      // R10 fallback beats stop
      stop = 1; ext = 0; loss = 1; tick();
      chk("R10", "fallback over stop", mode, M_SELF);
      stop = 0; ext = 1; loss = 0; tick();
      chk("R10", "back to loop external", mode, M_LEXT);

      // Stop and interrupt wake with select 11
      stop = 1; tick(); stop = 0;
      chk("R6", "off entered", mode, M_OFF);
      chk("R6", "clk_en low in off", clk_en, 0);
      filt_req = 1; #1;
      chk("R5", "filt_we blocked in off", filt_we, 0);
      filt_req = 0;
      tick(3);
      chk("R6", "stays off", mode, M_OFF);
      osc = 0; wake = 1; tick(); wake = 0;
      chk("R4", "wake to self while dco unstable", mode, M_SELF);
      chk("R6", "select kept", sel, 3);
      tick(3);
      chk("R4", "waits for oscillator", mode, M_SELF);
      osc = 1; tick();
      chk("R4", "enters loop external when stable", mode, M_LEXT);

      // Wake with select 10
      write_sel(2'b10);
      stop = 1; tick(); stop = 0;
      wake = 1; tick(); wake = 0;
      chk("R4", "wake to bypass directly", mode, M_BYP);
      chk("R7", "bypass clk_en held low", clk_en, 0);

      // Wake with select 00, written while off
      stop = 1; tick(); stop = 0;
      write_sel(2'b00);
      chk("R6", "select write does not leave off", mode, M_OFF);
      wake = 1; tick(); wake = 0;
      chk("R4", "wake to self for 00", mode, M_SELF);

      // Reset while off
      write_sel(2'b11);
      stop = 1; tick(); stop = 0;
      chk("R6", "off before reset", mode, M_OFF);
      rst_n = 0; #1;
      chk("R1", "reset wake mode", mode, M_SELF);
      chk("R1", "reset wake select", sel, 0);
      tick(); rst_n = 1; tick(2);
      chk("R1", "self after reset wake", mode, M_SELF);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule